// File: doc/BRIEF.md
# Smart Card Character Engine

This block moves 8-bit characters over a single open-drain data line shared with a smart card. Each character is a low start bit, eight data bits with the least significant bit first, and an even parity bit. Every bit lasts one elementary time unit (etu), which is a fixed number of clock cycles set by a parameter. The engine drives the line only by pulling it low. It reads the wired level back through a synchronizer.

With smart card mode on and T=0 selected, the engine runs character-level error recovery. On a parity error, the receiver pulls the line low for one etu as a NACK. On a NACK from the far end, the transmitter sends the same character again. When the retransmissions run out, the transmitter locks until a FIFO-clear pulse releases it, and it can raise an error interrupt. In T=1, and in plain UART mode (smart card mode off), a parity error only produces an error pulse on the receive side. A programmable extra guard time stretches the spacing of transmitted characters. The code 0xFF selects the protocol minimum.

In half-duplex mode the receiver ignores the line while the transmitter is busy. In full-duplex mode the receiver also decodes the engine's own transmitted characters.

Top module: `sc_uart_engine`

## Requirements
- R1: A transmitted character drives `line_low_o` high for each bit that is 0 and low for each bit that is 1. The bits are, in order: start (0), data bit 0 to data bit 7, and parity, which equals the XOR of the data byte. Each bit lasts ETU_CLKS cycles. The first bit is driven from the clock edge that accepts `tx_valid_i` while `tx_ready_o` is 1. At other times the transmitter leaves the line released.
- R2: A received character whose start bit is still low at mid-bit, and whose nine data and parity bits have an even number of ones, produces a one-cycle `rx_valid_o` pulse. `rx_data_o` carries the byte, assembled with the least significant bit first. Bits are sampled near the middle of each etu.
- R3: A received character with odd parity produces a one-cycle `rx_err_o` pulse and no `rx_valid_o` pulse.
- R4: A parity error pulls `line_low_o` high for exactly ETU_CLKS cycles when all of these hold: `sc_en_i`=1, `proto_t1_i`=0 and `nack_dis_i`=0. The pull starts no earlier than 10.5 etu and at most 4 cycles later than 10.5 etu after the start edge. With `nack_dis_i`=1, `proto_t1_i`=1 or `sc_en_i`=0, no NACK is driven.
- R5: With `sc_en_i`=1 and `proto_t1_i`=0, the transmitter samples the line at 11 etu. A low level there causes the same byte to be sent again, starting exactly one character period after the previous start bit. This repeats for at most `retry_max_i` retransmissions. After a character that is not NACKed, the transmitter becomes ready again.
- R6: A NACK on a character that has already used all `retry_max_i` retransmissions locks the transmitter. `tx_locked_o`=1 and `tx_ready_o`=0, and no start bit is sent while locked, even with `tx_valid_i` held high. `tx_err_irq_o` is set if `tx_err_ie_i` was 1, and stays clear otherwise.
- R7: A `fifo_clr_i` pulse takes priority over everything else. On the next cycle it clears the lock and the interrupt, aborts a character in progress, releases the line and sets `tx_ready_o`.
- R8: The start-to-start spacing of back-to-back transmitted characters is L*ETU_CLKS or L*ETU_CLKS+1 cycles. L is 12 in T=0 smart card mode and 11 otherwise, plus `guard_i` extra etus. A `guard_i` of 0xFF counts as 0 extra.
- R9: With `half_duplex_i`=1, the receiver reports nothing for the engine's own transmission. With `half_duplex_i`=0, the transmitted byte is also reported on `rx_data_o` with `rx_valid_o`.
- R10: With `sc_en_i`=0, or with `proto_t1_i`=1, a low level at 11 etu from the far end causes no retransmission and no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_en_i | input | 1 | Smart card mode enable (0: plain UART) |
| half_duplex_i | input | 1 | Receiver ignores the line while transmitting |
| proto_t1_i | input | 1 | Protocol select: 0 = T=0, 1 = T=1 |
| nack_dis_i | input | 1 | Suppress NACK on receive parity errors (T=0 only) |
| retry_max_i | input | 3 | Maximum retransmissions after a NACK |
| guard_i | input | 8 | Extra guard etus between characters; 0xFF = minimum |
| tx_err_ie_i | input | 1 | Enable for the transmit error interrupt |
| fifo_clr_i | input | 1 | Clear pulse: unlock and abort the transmitter |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| tx_locked_o | output | 1 | Transmitter locked after too many retries |
| tx_err_irq_o | output | 1 | Transmit error interrupt |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid pulse |
| rx_err_o | output | 1 | Receive parity error pulse |
| line_i | input | 1 | Level of the shared data line |
| line_low_o | output | 1 | Pull the data line low |

## Verification
The bench builds the engine with ETU_CLKS=8 and SYNC_STAGES=2. This short etu puts whole T=0 retransmission sequences within a few hundred cycles, up to lockout with retry limits from 0 to 3 and the guard code 0xFF. With eight cycles per etu, the NACK window and the 11-etu sample point each fall a few cycles clear of the synchronizer delay. The bench can therefore measure the NACK start cycle and its exact length.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_LOCK} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_NACK} rx_state_e;

  localparam int unsigned FRAME_T0 = 12;
  localparam int unsigned FRAME_T1 = 11;

  function automatic logic [7:0] extra_etu(input logic [7:0] g);
    return (g == 8'hFF) ? 8'd0 : g;
  endfunction
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b1;
        else if (i == 0) ff_q[i] <= d_i;
        else ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int unsigned ETU_CLKS = 372
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       t0_i,
  input  logic [7:0] guard_i,
  input  logic [2:0] retry_max_i,
  input  logic       err_ie_i,
  input  logic       clr_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       line_s_i,
  output logic       ready_o,
  output logic       busy_o,
  output logic       low_o,
  output logic       locked_o,
  output logic       irq_o
);
  localparam int unsigned SUB_W = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
  localparam int unsigned ETU_W = 9;

  tx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [ETU_W-1:0] etu_q, len_q;
  logic [7:0]       data_q;
  logic [2:0]       retry_q;
  logic             t0_q, nack_q, irq_q;
  logic             last_sub, last_etu, bit_hi;
  logic [ETU_W-1:0] bit_idx;

  assign last_sub = (sub_q == SUB_W'(ETU_CLKS-1));
  assign last_etu = (etu_q == len_q - 9'd1);
  assign bit_idx  = etu_q - 9'd1;

  always_comb begin
    bit_hi = 1'b1;
    if (etu_q == 9'd0)      bit_hi = 1'b0;
    else if (etu_q <= 9'd8) bit_hi = data_q[bit_idx[2:0]];
    else if (etu_q == 9'd9) bit_hi = ^data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sub_q   <= '0;
      etu_q   <= '0;
      len_q   <= 9'(FRAME_T1);
      data_q  <= '0;
      retry_q <= '0;
      t0_q    <= 1'b0;
      nack_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else if (clr_i) begin
      state_q <= TX_IDLE;
      retry_q <= '0;
      nack_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (valid_i) begin
          state_q <= TX_SEND;
          data_q  <= data_i;
          sub_q   <= '0;
          etu_q   <= '0;
          retry_q <= '0;
          nack_q  <= 1'b0;
          t0_q    <= t0_i;
          len_q   <= (t0_i ? 9'(FRAME_T0) : 9'(FRAME_T1)) + {1'b0, extra_etu(guard_i)};
        end
        TX_SEND: begin
          sub_q <= last_sub ? '0 : sub_q + 1'b1;
          if (last_sub) etu_q <= etu_q + 9'd1;
          // NACK probe at 11 etu, T=0 only
          if (t0_q && etu_q == 9'd11 && sub_q == '0 && !line_s_i) nack_q <= 1'b1;
          if (last_sub && last_etu) begin
            if (!nack_q) begin
              state_q <= TX_IDLE;
            end else if (retry_q == retry_max_i) begin
              state_q <= TX_LOCK;
              irq_q   <= err_ie_i;
            end else begin
              retry_q <= retry_q + 3'd1;
              nack_q  <= 1'b0;
              etu_q   <= '0;
            end
          end
        end
        default: state_q <= TX_LOCK;
      endcase
    end
  end

  assign ready_o  = (state_q == TX_IDLE);
  assign busy_o   = (state_q == TX_SEND);
  assign locked_o = (state_q == TX_LOCK);
  assign irq_o    = irq_q;
  assign low_o    = busy_o && !bit_hi;
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int unsigned ETU_CLKS = 372
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_s_i,
  input  logic       lock_i,
  input  logic       nack_en_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       err_o,
  output logic       low_o
);
  localparam int unsigned SUB_W = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
  localparam logic [SUB_W-1:0] HALF = SUB_W'(ETU_CLKS/2);

  rx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [3:0]       etu_q;
  logic [7:0]       sh_q, data_q;
  logic             prev_q, valid_q, err_q, last_sub, mid, par_ok;

  assign last_sub = (sub_q == SUB_W'(ETU_CLKS-1));
  assign mid      = (sub_q == HALF);
  assign par_ok   = ~^{sh_q, line_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      etu_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      prev_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      prev_q  <= line_s_i;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (state_q != RX_IDLE) begin
        sub_q <= last_sub ? '0 : sub_q + 1'b1;
        if (last_sub) etu_q <= etu_q + 4'd1;
      end
      unique case (state_q)
        RX_IDLE: if (prev_q && !line_s_i && !lock_i) begin
          state_q <= RX_DATA;
          sub_q   <= '0;
          etu_q   <= '0;
        end
        RX_DATA: if (mid) begin
          if (etu_q == 4'd0) begin
            if (line_s_i) state_q <= RX_IDLE;
          end else if (etu_q <= 4'd8) begin
            sh_q <= {line_s_i, sh_q[7:1]};
          end else begin
            data_q  <= sh_q;
            valid_q <= par_ok;
            err_q   <= !par_ok;
            state_q <= (!par_ok && nack_en_i) ? RX_NACK : RX_IDLE;
          end
        end
        RX_NACK: if (etu_q == 4'd11 && mid) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign low_o   = (state_q == RX_NACK) &&
                   ((etu_q == 4'd10 && sub_q >= HALF) || (etu_q == 4'd11 && sub_q < HALF));
endmodule

// File: rtl/sc_uart_engine.sv
module sc_uart_engine #(
  parameter int unsigned ETU_CLKS    = 372,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sc_en_i,
  input  logic       half_duplex_i,
  input  logic       proto_t1_i,
  input  logic       nack_dis_i,
  input  logic [2:0] retry_max_i,
  input  logic [7:0] guard_i,
  input  logic       tx_err_ie_i,
  input  logic       fifo_clr_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic       tx_locked_o,
  output logic       tx_err_irq_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       rx_err_o,
  input  logic       line_i,
  output logic       line_low_o
);
  logic line_s, t0_mode, tx_busy, tx_low, rx_low;

  assign t0_mode = sc_en_i && !proto_t1_i;

  sc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  sc_tx #(.ETU_CLKS(ETU_CLKS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .t0_i       (t0_mode),
    .guard_i    (guard_i),
    .retry_max_i(retry_max_i),
    .err_ie_i   (tx_err_ie_i),
    .clr_i      (fifo_clr_i),
    .data_i     (tx_data_i),
    .valid_i    (tx_valid_i),
    .line_s_i   (line_s),
    .ready_o    (tx_ready_o),
    .busy_o     (tx_busy),
    .low_o      (tx_low),
    .locked_o   (tx_locked_o),
    .irq_o      (tx_err_irq_o)
  );

  sc_rx #(.ETU_CLKS(ETU_CLKS)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_s_i (line_s),
    .lock_i   (half_duplex_i && tx_busy),
    .nack_en_i(t0_mode && !nack_dis_i),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o),
    .err_o    (rx_err_o),
    .low_o    (rx_low)
  );

  assign line_low_o = tx_low || rx_low;
endmodule

// File: rtl/sc_uart_engine_chk.sv
module sc_uart_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fifo_clr_i,
  input logic tx_ready_o,
  input logic tx_locked_o,
  input logic tx_err_irq_o,
  input logic rx_valid_o,
  input logic rx_err_o
);
  AST_LOCK_BLOCKS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_locked_o |-> !tx_ready_o); // R6
  AST_IRQ_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_irq_o |-> tx_locked_o); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_locked_o && !fifo_clr_i) |=> tx_locked_o); // R6
  AST_CLR_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (tx_ready_o && !tx_locked_o && !tx_err_irq_o)); // R7
  AST_RX_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_err_o)); // R3
  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R2
endmodule

bind sc_uart_engine sc_uart_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_clr_i  (fifo_clr_i),
  .tx_ready_o  (tx_ready_o),
  .tx_locked_o (tx_locked_o),
  .tx_err_irq_o(tx_err_irq_o),
  .rx_valid_o  (rx_valid_o),
  .rx_err_o    (rx_err_o)
);

// File: tb/sim_sc_uart_engine.sv
`timescale 1ns/1ps
module sim_sc_uart_engine;
  localparam int P = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sc_en, half, t1, nack_dis, ie, clr, tx_valid, card_low;
  logic [2:0] retry;
  logic [7:0] guard, tx_data, rx_data_o;
  logic tx_ready_o, tx_locked_o, tx_err_irq_o, rx_valid_o, rx_err_o, line_low_o, line_i;

  assign line_i = ~(line_low_o | card_low);
  always #2.5 clk = ~clk;

  sc_uart_engine #(.ETU_CLKS(P), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sc_en_i(sc_en), .half_duplex_i(half),
    .proto_t1_i(t1), .nack_dis_i(nack_dis), .retry_max_i(retry), .guard_i(guard),
    .tx_err_ie_i(ie), .fifo_clr_i(clr), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready_o), .tx_locked_o(tx_locked_o), .tx_err_irq_o(tx_err_irq_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_err_o(rx_err_o),
    .line_i(line_i), .line_low_o(line_low_o));

  int checks = 0, fails = 0, rx_cnt = 0, err_cnt = 0;
  longint cyc = 0;
  logic [7:0] rx_last = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rx_valid_o) begin rx_cnt++; rx_last = rx_data_o; end
    if (rx_err_o) err_cnt++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input longint act,
                         input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic int frame_len(input logic t0, input logic [7:0] g);
    return (t0 ? 12 : 11) + ((g == 8'hFF) ? 0 : int'(g));
  endfunction

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  // Observe an engine frame as the card; optionally answer with a NACK
  task automatic capture(input bit nack, input int tmo, output bit seen,
                         output logic [7:0] d, output bit pok, output longint ts);
    logic [9:0] bits;
    seen = 0; d = '0; pok = 0; ts = 0; bits = '0;
    for (int w = 0; w < tmo; w++) begin
      if (line_low_o) begin seen = 1; break; end
      @(negedge clk);
    end
    if (!seen) return;
    ts = cyc;
    for (int c = 0; c < (nack ? 11*P+P/2 : 10*P); c++) begin
      if (c > 0) @(negedge clk);
      if (c % P == P/2 && c / P < 10) bits[c/P] = line_i;
      if (nack) card_low = (c >= 10*P+P/2);
    end
    @(negedge clk); card_low = 1'b0;
    d = bits[8:1];
    pok = (bits[0] == 1'b0) && (^bits[9:1] == 1'b0);
  endtask

  task automatic card_send(input logic [7:0] d, input bit badpar,
                           output int nfirst, output int nlen);
    logic [9:0] bits;
    bits = {(^d) ^ badpar, d, 1'b0};
    nfirst = -1; nlen = 0;
    @(negedge clk);
    for (int c = 0; c < 12*P; c++) begin
      card_low = (c < 10*P) ? !bits[c/P] : 1'b0;
      if (line_low_o) begin if (nfirst < 0) nfirst = c; nlen++; end
      @(negedge clk);
    end
    card_low = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_pulse();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic period_run(input logic t0, input string req);
    bit s1, s2, p1, p2; logic [7:0] d1, d2, b; longint ts1, ts2; int len;
    for (int i = 0; i < 6; i++) begin
      guard = (i == 2) ? 8'hFF : 8'($urandom_range(0, 4));
      len = frame_len(t0, guard);
      b = 8'($urandom);
      if (i == 0) b = 8'h00;
      if (i == 1) b = 8'hFF;
      @(negedge clk); tx_data = b; tx_valid = 1'b1;
      capture(0, 20, s1, d1, p1, ts1);
      capture(0, len*P + 10, s2, d2, p2, ts2);
      tx_valid = 1'b0;
      chk("R1", "tx data", d1, b);
      chk("R1", "tx parity/start ok", p1, 1);
      chk("R1", "second frame seen", s2, 1);
      chk_rng(req, "char period", ts2 - ts1, len*P, len*P + 1);
      repeat (len*P) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit s; bit pk; logic [7:0] d, b; longint ts, tp; int nf, nl, r0, e0, n, rmax;
    void'($urandom(32'd7816));
    sc_en = 1; half = 1; t1 = 0; nack_dis = 0; retry = 0; guard = 0; ie = 1;
    clr = 0; tx_valid = 0; tx_data = 0; card_low = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "line released after reset", line_low_o, 0);
    chk("R6", "not locked after reset", tx_locked_o, 0);
    chk("R7", "ready after reset", tx_ready_o, 1);

    // R8 / R1: T=1 and T=0 spacing
    t1 = 1; period_run(0, "R8 T1");
    t1 = 0; period_run(1, "R8 T0");
    sc_en = 0; period_run(0, "R8 plain");

    // R10: plain mode ignores far-end low at 11 etu
    guard = 0; b = 8'h5A; send_tx(b);
    capture(1, 20, s, d, pk, ts);
    capture(0, 11*P + 20, s, d, pk, tp);
    chk("R10", "plain: no retransmission", s, 0);
    chk("R10", "plain: not locked", tx_locked_o, 0);
    sc_en = 1; t1 = 1; retry = 0; send_tx(8'hA5);
    capture(1, 20, s, d, pk, ts);
    capture(0, 11*P + 20, s, d, pk, tp);
    chk("R10", "T1: no retransmission", s, 0);
    chk("R10", "T1: not locked", tx_locked_o, 0);

    // R5: NACK twice then accept
    t1 = 0; retry = 2; b = 8'($urandom); send_tx(b);
    capture(1, 20, s, d, pk, ts);
    capture(1, 12*P + 10, s, d, pk, tp);
    chk("R5", "first retransmission same byte", d, b);
    chk("R5", "retransmission spacing", tp - ts, 12*P);
    capture(0, 12*P + 10, s, d, pk, ts);
    chk("R5", "second retransmission seen", s, 1);
    chk("R5", "second retransmission byte", d, b);
    repeat (3*P) @(negedge clk);
    capture(0, 12*P, s, d, pk, tp);
    chk("R5", "no further frame", s, 0);
    chk("R5", "ready again", tx_ready_o, 1);

    // R6: always NACK until lock
    rmax = $urandom_range(1, 3); retry = 3'(rmax); ie = 1; guard = 8'd1;
    send_tx(8'($urandom));
    n = 0;
    for (int k = 0; k < 10; k++) begin
      capture(1, 13*P + 10, s, d, pk, ts);
      if (!s) break;
      n++;
    end
    chk("R6", "frames sent before lock", n, rmax + 1);
    chk("R6", "locked", tx_locked_o, 1);
    chk("R6", "not ready when locked", tx_ready_o, 0);
    chk("R6", "irq raised", tx_err_irq_o, 1);
    @(negedge clk); tx_valid = 1'b1; n = 0;
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (line_low_o) n++; end
    tx_valid = 1'b0;
    chk("R6", "no start bit while locked", n, 0);
    clr_pulse();
    chk("R7", "unlocked by clear", tx_locked_o, 0);
    chk("R7", "irq cleared", tx_err_irq_o, 0);
    chk("R7", "ready after clear", tx_ready_o, 1);

    // R6: retry 0, interrupt disabled
    retry = 0; ie = 0; guard = 0; send_tx(8'h3C);
    capture(1, 20, s, d, pk, ts);
    capture(0, 12*P + 10, s, d, pk, tp);
    chk("R6", "retry0: no retransmission", s, 0);
    chk("R6", "retry0: locked", tx_locked_o, 1);
    chk("R6", "retry0: irq masked", tx_err_irq_o, 0);
    clr_pulse();

    // R2: receive good characters
    half = 1;
    for (int k = 0; k < 8; k++) begin
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      r0 = rx_cnt;
      card_send(b, 0, nf, nl);
      chk("R2", "rx valid count", rx_cnt - r0, 1);
      chk("R2", "rx data", rx_last, b);
      chk("R4", "no NACK on good parity", nl, 0);
    end

    // R3/R4: parity errors
    r0 = rx_cnt; e0 = err_cnt;
    card_send(8'h96, 1, nf, nl);
    chk("R3", "T0 err pulse", err_cnt - e0, 1);
    chk("R3", "T0 no valid on error", rx_cnt - r0, 0);
    chk_rng("R4", "NACK start", nf, 10*P + P/2, 10*P + P/2 + 4);
    chk("R4", "NACK length", nl, P);
    nack_dis = 1; e0 = err_cnt;
    card_send(8'h11, 1, nf, nl);
    chk("R4", "nack_dis: no NACK", nl, 0);
    chk("R3", "nack_dis: err pulse", err_cnt - e0, 1);
    nack_dis = 0; t1 = 1; e0 = err_cnt; r0 = rx_cnt;
    card_send(8'h22, 1, nf, nl);
    chk("R4", "T1: no NACK", nl, 0);
    chk("R3", "T1: err pulse", err_cnt - e0, 1);
    chk("R3", "T1: no valid", rx_cnt - r0, 0);
    sc_en = 0; e0 = err_cnt;
    card_send(8'h44, 1, nf, nl);
    chk("R4", "plain: no NACK", nl, 0);
    chk("R3", "plain: err pulse", err_cnt - e0, 1);

    // R9: half- vs full-duplex echo
    sc_en = 1; t1 = 1; half = 0; b = 8'($urandom); r0 = rx_cnt;
    send_tx(b); capture(0, 20, s, d, pk, ts);
    repeat (30) @(negedge clk);
    chk("R9", "full duplex echo count", rx_cnt - r0, 1);
    chk("R9", "full duplex echo data", rx_last, b);
    half = 1; r0 = rx_cnt;
    send_tx(8'h69); capture(0, 20, s, d, pk, ts);
    repeat (30) @(negedge clk);
    chk("R9", "half duplex no echo", rx_cnt - r0, 0);

    // R7: abort mid-frame
    send_tx(8'h00);
    repeat (20) @(negedge clk);
    chk("R1", "start/data driving low mid-frame", line_low_o, 1);
    clr_pulse();
    chk("R7", "line released by clear", line_low_o, 0);
    chk("R7", "ready after abort", tx_ready_o, 1);
    n = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (line_low_o) n++; end
    chk("R7", "no drive after abort", n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule